// File: doc/BRIEF.md
# Trace-back Viterbi decoder

This block decodes a hard-decision stream protected by a rate-1/2, constraint-length-3 convolutional code with octal generators 7 and 5. Each accepted symbol is a 2-bit codeword. Four add-compare-select units update a bank of 6-bit path metrics and record one decision bit per state. The decisions go into survivor storage built from four rotating banks of 15 columns each. Decoded bits leave in transmission order, one per handshake.

Both stream edges use valid/ready. The decoder moves one trellis step for each accepted symbol, and it stops when no symbol is accepted. Within one 15-step period, one bank is filled. The bank filled just before it is traced from the state with the lowest metric, and this trace finds the state at which the older bank ends. The older bank is then traced from that state to recover its 15 bits. The trace runs two steps per accepted symbol, so both walks end together at the period boundary. The recovered bits are then handed to a one-segment output buffer.

Back-pressure works in one direction only. The decoder lowers `sym_ready` only on the last step of a period, and only when the output buffer would still hold bits at that edge. A synchronous reset zeroes every path metric and empties the buffer.

Top module: `tbvit_decoder`

## Requirements
- R1: After reset, `bit_valid` is 0 and `sym_ready` is 1. Every path metric starts at zero, so no start state is assumed.
- R2: The codeword for input bit u in state {s1,s0} is `sym[1]` = u^s1^s0 and `sym[0]` = u^s0. The next state is {u,s1}, where s1 is the previous input. For an error-free stream, the decoded bits equal the encoder's input bits in order, starting from its first bit.
- R3: A single flipped codeword bit, with at least 20 clean codewords on each side, does not change the decoded bits.
- R4: Decoded bits come out in segments of 15. The first `bit_valid` appears in the cycle after the 45th accepted symbol. Each later segment becomes available in the cycle after every further 15th accepted symbol.
- R5: `sym_ready` is 0 exactly when three conditions hold: the next accepted symbol would be the 15th of a period, at least 44 symbols have been accepted, and the output buffer holds more than one bit, or holds one bit while `bit_ready` is 0. At all other times `sym_ready` is 1.
- R6: While `bit_valid` is high and `bit_ready` is low, `bit_valid` and `bit_out` hold in the next cycle.
- R7: Path metrics are renormalised after every step so that the smallest is zero, and they stay below half their range. When two candidate sums are equal, the predecessor with the lower number wins. Decoding stays correct over long runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | Received codeword is present |
| sym_ready | output | 1 | Decoder accepts the codeword this cycle |
| sym | input | 2 | Received hard-decision codeword (bit 1 from generator 7) |
| bit_valid | output | 1 | A decoded bit is present |
| bit_ready | input | 1 | Consumer takes the decoded bit this cycle |
| bit_out | output | 1 | Decoded bit, in transmission order |

## Verification
The assertions assume that the received stream comes from a code with a small metric spread, which keeps the renormalised metrics well below half range. They also assume that the sink obeys the handshake: a bit counts as taken only when `bit_valid` and `bit_ready` are both high. The stimulus encodes random bits with a matching 7,5 encoder. Every single-bit error it injects is at least 22 clean codewords away from the next, so single-error correction is within reach. The stimulus also toggles `sym_valid` and `bit_ready` at random, so the stall on the last step of a period is exercised with the buffer holding many bits, one bit and none.

// File: rtl/tbvit_pkg.sv
package tbvit_pkg;
  localparam int NS = 4;

  // expected codeword leaving state s={s1,s0} on input u
  function automatic logic [1:0] branch_cw(input logic [1:0] s, input logic u);
    return {u ^ s[1] ^ s[0], u ^ s[0]};
  endfunction

  function automatic logic [1:0] hdist(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] x;
    x = a ^ b;
    return {x[1] & x[0], x[1] ^ x[0]};
  endfunction
endpackage

// File: rtl/tbvit_acs.sv
module tbvit_acs #(
  parameter int PMW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [PMW-1:0] pm_a,
  input  logic [PMW-1:0] pm_b,
  input  logic [1:0]     bm_a,
  input  logic [1:0]     bm_b,
  output logic [PMW-1:0] sum,
  output logic           dec
);
  logic [PMW-1:0] sa, sb;

  assign sa  = pm_a + PMW'(bm_a);
  assign sb  = pm_b + PMW'(bm_b);
  assign dec = sb < sa;
  assign sum = dec ? sb : sa;

  // R7: equal sums keep the lower-numbered predecessor
  p_tie_low_r7: assert property (@(posedge clk) disable iff (rst)
    (sa == sb) |-> (!dec && sum == sa));
endmodule

// File: rtl/tbvit_survivor.sv
module tbvit_survivor import tbvit_pkg::*; #(
  parameter int L  = 15,
  parameter int PW = $clog2(L)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [PW-1:0] pos,
  input  logic [1:0]    wbank,
  input  logic [NS-1:0] dec,
  input  logic [1:0]    best,
  output logic [L-1:0]  seg
);
  logic [NS-1:0] mem [4][L];
  logic [1:0]    tst, s_cur, bk;
  logic [L-1:0]  dbits;
  int            j, col;

  // two trace steps per symbol: first through the newest full bank, then the older one
  always_comb begin
    s_cur = (pos == '0) ? best : tst;
    seg   = dbits;
    j     = 0;
    col   = 0;
    bk    = '0;
    for (int k = 0; k < 2; k++) begin
      j = 2 * int'(pos) + k;
      if (j < L) begin
        bk  = wbank - 2'd1;
        col = L - 1 - j;
      end else begin
        bk  = wbank - 2'd2;
        col = 2 * L - 1 - j;
        seg[PW'(col)] = s_cur[1];
      end
      s_cur = {s_cur[0], mem[bk][PW'(col)][s_cur]};
    end
  end

  always_ff @(posedge clk) begin
    if (step) mem[wbank][pos] <= dec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tst   <= '0;
      dbits <= '0;
    end else if (step) begin
      tst   <= s_cur;
      dbits <= seg;
    end
  end
endmodule

// File: rtl/tbvit_obuf.sv
module tbvit_obuf #(
  parameter int L  = 15,
  parameter int PW = $clog2(L),
  parameter int CW = $clog2(L + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [L-1:0] seg,
  input  logic         bit_ready,
  output logic         bit_valid,
  output logic         bit_out,
  output logic         busy
);
  logic [L-1:0]  bits;
  logic [PW-1:0] rd;
  logic [CW-1:0] cnt;
  logic          pop;

  assign bit_valid = cnt != '0;
  assign bit_out   = bits[rd];
  assign pop       = bit_valid && bit_ready;
  assign busy      = (cnt > CW'(1)) || (cnt == CW'(1) && !bit_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      rd   <= '0;
      bits <= '0;
    end else if (load) begin
      bits <= seg;
      cnt  <= CW'(L);
      rd   <= '0;
    end else if (pop) begin
      cnt <= cnt - CW'(1);
      rd  <= rd + PW'(1);
    end
  end

  // R5: a new segment never overwrites bits still waiting
  p_no_clobber_r5: assert property (@(posedge clk) disable iff (rst)
    load |-> (cnt == '0 || (cnt == CW'(1) && bit_ready)));
endmodule

// File: rtl/tbvit_decoder.sv
module tbvit_decoder import tbvit_pkg::*; #(
  parameter int L   = 15,
  parameter int PMW = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_valid,
  output logic       sym_ready,
  input  logic [1:0] sym,
  output logic       bit_valid,
  input  logic       bit_ready,
  output logic       bit_out
);
  localparam int PW   = $clog2(L);
  localparam int HALF = 2 ** (PMW - 1);

  logic [PMW-1:0] pm  [NS];
  logic [PMW-1:0] sum [NS];
  logic [NS-1:0]  dec;
  logic [PMW-1:0] minv, pmin;
  logic [1:0]     best, wbank, nper;
  logic [PW-1:0]  pos;
  logic           step, primed, last, busy, load;
  logic [L-1:0]   seg;

  assign primed    = nper == 2'd2;
  assign last      = pos == PW'(L - 1);
  assign sym_ready = !(last && primed && busy);
  assign step      = sym_valid && sym_ready;
  assign load      = step && last && primed;

  generate
    for (genvar n = 0; n < NS; n++) begin : g_acs
      localparam int P0 = (n % 2) * 2;
      localparam int U  = n / 2;
      tbvit_acs #(.PMW(PMW)) u_acs (
        .clk (clk),
        .rst (rst),
        .pm_a(pm[P0]),
        .pm_b(pm[P0 + 1]),
        .bm_a(hdist(sym, branch_cw(2'(P0), 1'(U)))),
        .bm_b(hdist(sym, branch_cw(2'(P0 + 1), 1'(U)))),
        .sum (sum[n]),
        .dec (dec[n])
      );
    end
  endgenerate

  always_comb begin
    minv = sum[0];
    pmin = pm[0];
    for (int k = 1; k < NS; k++) begin
      if (sum[k] < minv) minv = sum[k];
      if (pm[k] < pmin) pmin = pm[k];
    end
    best = '0;
    for (int k = NS - 1; k >= 0; k--) begin
      if (pm[k] == pmin) best = 2'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NS; k++) pm[k] <= '0;
      pos   <= '0;
      wbank <= '0;
      nper  <= '0;
    end else if (step) begin
      for (int k = 0; k < NS; k++) pm[k] <= sum[k] - minv;
      pos <= last ? '0 : pos + PW'(1);
      if (last) begin
        wbank <= wbank + 2'd1;
        if (!primed) nper <= nper + 2'd1;
      end
    end
  end

  tbvit_survivor #(.L(L)) u_surv (
    .clk(clk), .rst(rst), .step(step), .pos(pos), .wbank(wbank),
    .dec(dec), .best(best), .seg(seg)
  );

  tbvit_obuf #(.L(L)) u_obuf (
    .clk(clk), .rst(rst), .load(load), .seg(seg), .bit_ready(bit_ready),
    .bit_valid(bit_valid), .bit_out(bit_out), .busy(busy)
  );

  // R7: renormalisation leaves a zero metric and keeps all below half range
  p_norm_zero_r7: assert property (@(posedge clk) disable iff (rst)
    step |=> (pm[0] == '0 || pm[1] == '0 || pm[2] == '0 || pm[3] == '0));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    pm[0] < PMW'(HALF) && pm[1] < PMW'(HALF) && pm[2] < PMW'(HALF) && pm[3] < PMW'(HALF));
  // R4: nothing is emitted before two full periods are stored
  p_gate_r4: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> primed);
  // R6: a stalled output holds
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_out)));
endmodule

// File: tb/sim_tbvit_decoder.sv
`timescale 1ns/1ps
module sim_tbvit_decoder;
  localparam int L = 15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sym_valid = 1'b0;
  logic [1:0] sym = 2'b00;
  logic       bit_ready = 1'b0;
  logic       sym_ready, bit_valid, bit_out;

  tbvit_decoder u0 (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_ready(sym_ready), .sym(sym),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_out(bit_out)
  );

  always #2 clk = ~clk;

  int         checks = 0, errors = 0;
  bit         src_q[$];
  int         nacc = 0, avail = 0, outn = 0;
  logic [1:0] enc = 2'b00;
  bit         pend = 1'b0;
  bit         prev_stall = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycle(input bit v, input bit rdy);
    bit         exp_rdy, acc, pop;
    logic [1:0] m;
    string      tag;
    @(negedge clk);
    sym_valid = v;
    bit_ready = rdy;
    m = (nacc >= 200 && nacc % 23 == 11) ? ((nacc % 2 == 1) ? 2'b01 : 2'b10) : 2'b00;
    sym = {pend ^ enc[1] ^ enc[0], pend ^ enc[0]} ^ m;
    #1;
    exp_rdy = !((nacc % L == L - 1) && nacc >= 3 * L - 1 &&
                (avail > 1 || (avail == 1 && !rdy)));
    chk(sym_ready == exp_rdy, "R5 sym_ready", int'(sym_ready), int'(exp_rdy));
    chk(bit_valid == (avail > 0), "R4 bit_valid", int'(bit_valid), int'(avail > 0));
    if (avail > 0 && bit_valid) begin
      if (prev_stall)      tag = "R6 held bit";
      else if (outn < 200) tag = "R2 clean bit";
      else                 tag = "R3 corrected bit";
      chk(bit_out == src_q[0], tag, int'(bit_out), int'(src_q[0]));
    end
    pop = rdy && avail > 0;
    if (pop) begin
      void'(src_q.pop_front());
      avail--;
      outn++;
    end
    acc = v && exp_rdy;
    if (acc) begin
      src_q.push_back(pend);
      if (nacc % L == L - 1 && nacc >= 3 * L - 1) avail = L;
      enc  = {pend, enc[1]};
      nacc++;
      pend = 1'($urandom % 2);
    end
    prev_stall = (avail > 0) && !rdy;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL R4 watchdog actual %0d expected %0d", nacc, 2100);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pend = 1'($urandom % 2);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: idle after reset
    chk(bit_valid == 1'b0, "R1 bit_valid after reset", int'(bit_valid), 0);
    chk(sym_ready == 1'b1, "R1 sym_ready after reset", int'(sym_ready), 1);
    // R2/R4: steady stream, clean first 200 codewords
    repeat (300) cycle(1'b1, 1'b1);
    // R3/R5/R6: random gaps on both edges with isolated errors
    repeat (1500) cycle(($urandom % 4) != 0, ($urandom % 3) != 0);
    repeat (300) cycle(1'b1, 1'b1);
    // R7: long run keeps decoding up to the pipeline depth
    chk(outn >= nacc - 4 * L, "R7 long run output count", outn, nacc - 4 * L);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule